// File: doc/BRIEF.md
# Spectrum Corner-Turn Reorder Buffer

This block sits between a streaming FFT and a cross-multiply stage. Each FFT segment arrives as NCH complex spectral words in ascending channel order. The block gathers NSEG whole segments (one frame) in a memory bank. It then plays that frame back channel by channel: all NSEG samples of channel 0, ordered from the oldest segment to the newest, then all NSEG samples of channel 1, and so on. The multiplier that follows sees the same frequency channel several times in a row, so it can sum into a simple register and needs no per-channel short-term memory.

There are two banks. One bank fills while the other drains. Both streams use a valid/ready handshake. The output word carries its channel index and markers for the first and last member of each channel group. NCH and NSEG must be powers of two and at least 2.

The write controller has two states. In WR_OPEN it accepts words. It goes to WR_BLOCKED when it finishes a frame and the next bank is still marked full. It goes back to WR_OPEN once that bank is released. The read controller also has two states. RD_IDLE waits until the current read bank is marked full, then goes to RD_STREAM. RD_STREAM loads the output register whenever the register is empty or being taken. After the last word of a frame it chains straight into the other bank if that bank is already full. Otherwise it falls back to RD_IDLE.

Top module: `ctb_corner_turn`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A word is accepted on each rising edge where in_valid and in_ready are both 1. Accepted words are taken as channel 0..NCH-1 of segment 0, then the same for segment 1, up to segment NSEG-1. Each group of NSEG segments forms one frame. Every accepted word is delivered exactly once.
- R3: Within a frame, output order is channel-major with the segment as the inner index. Output k of frame f carries the input word of segment (k mod NSEG), channel (k div NSEG) of that frame. Frames come out in arrival order.
- R4: out_chan equals the channel index of the word on out_data.
- R5: out_first is 1 exactly for the segment-0 sample of a channel group. out_last is 1 exactly for the segment NSEG-1 sample.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data, out_chan, out_first and out_last hold their values.
- R7: The block never holds more than 2·NSEG·NCH undelivered words plus the one in the output register. With out_ready held at 0, exactly 2·NSEG·NCH words are accepted and then in_ready stays 0.
- R8: A new frame is written while the previous one is read out. With both sides always ready, four frames pass from first acceptance to last delivery within 6·NSEG·NCH cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | DW | Spectral word, channel-ascending within a segment |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | DW | Reordered spectral word |
| out_chan | output | log2(NCH) | Channel index of out_data |
| out_first | output | 1 | First sample of a channel group |
| out_last | output | 1 | Last sample of a channel group |

## Verification
The bench goes after the bank handoff. If the full flags were handled wrongly, a write could overrun a bank that is still being read, so stale or newer segments would show up in a channel group; or the writer would never unblock and the run would hang. The directed stall fills both banks with the consumer stopped. A design that miscounts capacity would accept one word too many or too few. Random gaps on both sides test output hold under backpressure and the segment-inner ordering; a swapped loop nest would emit channel-ascending rows instead of groups. The throughput phase catches a design that serializes writing and reading of a frame.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
    typedef enum logic {
        WR_OPEN    = 1'b0,
        WR_BLOCKED = 1'b1
    } wr_state_t;

    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_STREAM = 1'b1
    } rd_state_t;
endpackage

// File: rtl/ctb_bank_mem.sv
module ctb_bank_mem #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/ctb_wr_ctrl.sv
module ctb_wr_ctrl
    import ctb_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NSEG = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [1:0]              bank_full,
    output logic                    in_ready,
    output logic                    wr_en,
    output logic                    wr_bank,
    output logic [$clog2(NSEG)-1:0] wr_seg,
    output logic [$clog2(NCH)-1:0]  wr_ch,
    output logic                    frame_done
);
    localparam int CW = $clog2(NCH);
    localparam int SW = $clog2(NSEG);
    localparam logic [CW-1:0] CH_MAX  = CW'(NCH - 1);
    localparam logic [SW-1:0] SEG_MAX = SW'(NSEG - 1);

    wr_state_t state, state_nxt;
    logic      accept;
    logic      at_end;

    assign accept = in_valid && (state == WR_OPEN);
    assign at_end = (wr_seg == SEG_MAX) && (wr_ch == CH_MAX);

    always_comb begin
        state_nxt = state;
        unique case (state)
            WR_OPEN: begin
                if (accept && at_end && bank_full[~wr_bank]) begin
                    state_nxt = WR_BLOCKED;
                end
            end
            WR_BLOCKED: begin
                if (!bank_full[wr_bank]) begin
                    state_nxt = WR_OPEN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WR_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ch   <= '0;
            wr_seg  <= '0;
            wr_bank <= 1'b0;
        end else if (accept) begin
            if (wr_ch == CH_MAX) begin
                wr_ch <= '0;
                if (wr_seg == SEG_MAX) begin
                    wr_seg  <= '0;
                    wr_bank <= ~wr_bank;
                end else begin
                    wr_seg <= wr_seg + 1'b1;
                end
            end else begin
                wr_ch <= wr_ch + 1'b1;
            end
        end
    end

    assign in_ready   = (state == WR_OPEN);
    assign wr_en      = accept;
    assign frame_done = accept && at_end;
endmodule

// File: rtl/ctb_rd_ctrl.sv
module ctb_rd_ctrl
    import ctb_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NCH  = 8,
    parameter int NSEG = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              bank_full,
    input  logic                    out_ready,
    input  logic [DW-1:0]           rd_data,
    output logic                    rd_bank,
    output logic [$clog2(NSEG)-1:0] rd_seg,
    output logic [$clog2(NCH)-1:0]  rd_ch,
    output logic                    bank_release,
    output logic                    out_valid,
    output logic [DW-1:0]           out_data,
    output logic [$clog2(NCH)-1:0]  out_chan,
    output logic                    out_first,
    output logic                    out_last
);
    localparam int CW = $clog2(NCH);
    localparam int SW = $clog2(NSEG);
    localparam logic [CW-1:0] CH_MAX  = CW'(NCH - 1);
    localparam logic [SW-1:0] SEG_MAX = SW'(NSEG - 1);

    rd_state_t state, state_nxt;
    logic      load;
    logic      at_end;

    assign load   = (state == RD_STREAM) && (!out_valid || out_ready);
    assign at_end = (rd_seg == SEG_MAX) && (rd_ch == CH_MAX);

    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_IDLE: begin
                if (bank_full[rd_bank]) begin
                    state_nxt = RD_STREAM;
                end
            end
            RD_STREAM: begin
                if (load && at_end && !bank_full[~rd_bank]) begin
                    state_nxt = RD_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_seg  <= '0;
            rd_ch   <= '0;
            rd_bank <= 1'b0;
        end else if (load) begin
            if (rd_seg == SEG_MAX) begin
                rd_seg <= '0;
                if (rd_ch == CH_MAX) begin
                    rd_ch   <= '0;
                    rd_bank <= ~rd_bank;
                end else begin
                    rd_ch <= rd_ch + 1'b1;
                end
            end else begin
                rd_seg <= rd_seg + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_chan  <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= rd_data;
            out_chan  <= rd_ch;
            out_first <= (rd_seg == '0);
            out_last  <= (rd_seg == SEG_MAX);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign bank_release = load && at_end;
endmodule

// File: rtl/ctb_corner_turn.sv
module ctb_corner_turn #(
    parameter int DW   = 32,
    parameter int NCH  = 8,
    parameter int NSEG = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [DW-1:0]          in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [DW-1:0]          out_data,
    output logic [$clog2(NCH)-1:0] out_chan,
    output logic                   out_first,
    output logic                   out_last
);
    localparam int CW = $clog2(NCH);
    localparam int SW = $clog2(NSEG);
    localparam int AW = 1 + SW + CW;

    logic [1:0]    bank_full;
    logic          wr_en, wr_bank, frame_done;
    logic [SW-1:0] wr_seg;
    logic [CW-1:0] wr_ch;
    logic          rd_bank, bank_release;
    logic [SW-1:0] rd_seg;
    logic [CW-1:0] rd_ch;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] wr_addr, rd_addr;

    // Same field layout on both sides: the read side swaps only loop nesting.
    assign wr_addr = {wr_bank, wr_seg, wr_ch};
    assign rd_addr = {rd_bank, rd_seg, rd_ch};

    ctb_wr_ctrl #(.NCH(NCH), .NSEG(NSEG)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .bank_full  (bank_full),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_seg     (wr_seg),
        .wr_ch      (wr_ch),
        .frame_done (frame_done)
    );

    ctb_rd_ctrl #(.DW(DW), .NCH(NCH), .NSEG(NSEG)) u_rd (
        .clk          (clk),
        .rst          (rst),
        .bank_full    (bank_full),
        .out_ready    (out_ready),
        .rd_data      (rd_data),
        .rd_bank      (rd_bank),
        .rd_seg       (rd_seg),
        .rd_ch        (rd_ch),
        .bank_release (bank_release),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_chan     (out_chan),
        .out_first    (out_first),
        .out_last     (out_last)
    );

    ctb_bank_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Full flag per bank: set by the writer, cleared by the reader.
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_full <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (frame_done && (wr_bank == 1'(b))) begin
                    bank_full[b] <= 1'b1;
                end else if (bank_release && (rd_bank == 1'(b))) begin
                    bank_full[b] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
    parameter int DW   = 32,
    parameter int NCH  = 8,
    parameter int NSEG = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [DW-1:0]          out_data,
    input logic [$clog2(NCH)-1:0] out_chan,
    input logic                   out_first,
    input logic                   out_last
);
    localparam int CW    = $clog2(NCH);
    localparam int FRAME = NCH * NSEG;
    localparam int OW    = $clog2(2 * FRAME + 2) + 2;

    logic [OW-1:0] occ;
    logic          acc, pop;

    assign acc = in_valid && in_ready;
    assign pop = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            occ <= occ + OW'(acc) - OW'(pop);
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst) |-> (in_ready && !out_valid));

    assert_no_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(2 * FRAME + 1));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable(out_chan) && $stable(out_first) && $stable(out_last)));

    assert_group_inner_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && !out_last) |=> (out_valid && !out_first
            && out_chan == $past(out_chan)));

    assert_chan_step_R4: assert property (@(posedge clk) disable iff (rst)
        (pop && out_last && out_chan != CW'(NCH - 1)) |=> (out_valid
            && out_first && out_chan == CW'($past(out_chan) + 1'b1)));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_first && out_last));
endmodule

bind ctb_corner_turn ctb_checker #(.DW(DW), .NCH(NCH), .NSEG(NSEG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_chan  (out_chan),
    .out_first (out_first),
    .out_last  (out_last)
);

// File: tb/ctb_corner_turn_test.sv
module ctb_corner_turn_test;
    localparam int DW    = 32;
    localparam int NCH   = 8;
    localparam int NSEG  = 4;
    localparam int CW    = $clog2(NCH);
    localparam int FRAME = NCH * NSEG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic [CW-1:0] out_chan;
    logic          out_first, out_last;

    ctb_corner_turn #(.DW(DW), .NCH(NCH), .NSEG(NSEG)) uut (.*);

    always #5 clk = ~clk;

    int            checks = 0;
    int            errors = 0;
    int            cycles = 0;
    int            acc_cnt = 0;
    int            out_cnt = 0;
    int            remaining = 0;
    bit            hold = 0;
    bit            prev_stall = 0;
    logic [DW-1:0] prev_data;
    logic [CW-1:0] prev_chan;
    logic [DW-1:0] in_log [1024];

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_index(int k);
        int f, r;
        f = k / FRAME;
        r = k % FRAME;
        return f * FRAME + (r % NSEG) * NCH + (r / NSEG);
    endfunction

    task automatic step(int vpct, int rpct);
        int idx, r;
        @(negedge clk);
        if (!hold) begin
            if (remaining > 0 && ($urandom % 100) < vpct) begin
                in_valid = 1'b1;
                in_data  = $urandom;
            end else begin
                in_valid = 1'b0;
            end
        end
        out_ready = (($urandom % 100) < rpct);
        if (prev_stall) begin
            chk(out_valid && out_data == prev_data && out_chan == prev_chan,
                "R6", "held output changed", out_data, prev_data);
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        prev_chan  = out_chan;
        if (in_valid && in_ready) begin
            in_log[acc_cnt] = in_data;
            acc_cnt++;
            remaining--;
            hold = 0;
        end else begin
            hold = in_valid;
        end
        if (out_valid && out_ready) begin
            idx = exp_index(out_cnt);
            r   = out_cnt % FRAME;
            chk(out_data == in_log[idx], "R3", "data order", out_data, in_log[idx]);
            chk(out_chan == CW'(r / NSEG), "R4", "channel index", out_chan, r / NSEG);
            chk(out_first == ((r % NSEG) == 0), "R5", "first flag", out_first, (r % NSEG) == 0);
            chk(out_last == ((r % NSEG) == NSEG - 1), "R5", "last flag", out_last,
                (r % NSEG) == NSEG - 1);
            out_cnt++;
        end
        chk(acc_cnt - out_cnt <= 2 * FRAME + 1, "R7", "occupancy", acc_cnt - out_cnt,
            2 * FRAME + 1);
        cycles++;
    endtask

    task automatic drain(int vpct, int rpct);
        int guard = 0;
        while ((remaining > 0 || hold || out_cnt != acc_cnt) && guard < 20000) begin
            step(vpct, rpct);
            guard++;
        end
        chk(out_cnt == acc_cnt, "R2", "all words delivered", out_cnt, acc_cnt);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", out_cnt, acc_cnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int t0, total;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // Directed: consumer stopped, both banks fill, then input stalls (R7).
        remaining = 3 * FRAME;
        for (int i = 0; i < 3 * FRAME; i++) step(100, 0);
        chk(acc_cnt == 2 * FRAME, "R7", "words accepted with consumer stopped",
            acc_cnt, 2 * FRAME);
        chk(in_ready == 1'b0, "R7", "in_ready while both banks full", in_ready, 0);
        chk(out_valid && out_first && out_chan == '0, "R5", "first output waiting",
            {out_valid, out_first, 4'(out_chan)}, 6'b110000);
        drain(100, 60);

        // Random gaps on both sides (R2, R3, R6).
        remaining = 6 * FRAME;
        drain(70, 50);
        remaining = 2 * FRAME;
        drain(30, 90);

        // Throughput with both sides always ready (R8).
        t0 = cycles;
        total = acc_cnt + 4 * FRAME;
        remaining = 4 * FRAME;
        drain(100, 100);
        chk(out_cnt == total, "R8", "four frames delivered", out_cnt, total);
        chk(cycles - t0 <= 6 * FRAME, "R8", "cycles for four frames", cycles - t0, 6 * FRAME);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule